// File: doc/BRIEF.md
# Pin-Strap Configuration Decoder

This block runs once after every reset. It works out how four selector inputs and a clock-output pin are wired on the board. Each of these pins may be tied low, tied high, or looped back to one of two probe outputs. The block drives the two probe outputs with two different patterns in two phases. After each phase has had time to settle, it samples the synchronized pins. Each pin then falls into one of four classes.

From the classes of selectors 0 and 1, the block derives a carrier-frequency index. From selectors 2 and 3, it derives a modem configuration index, together with its modulation type, bandwidth code and squelch flag. From the clock-output pin, it derives a flag that disables the system clock. If a selector combination is not in either table, the block raises an invalid flag and falls back to index 0. When decoding ends, the block raises a done flag and hands the probe pins back to their functional drivers. The decoded values hold until the next reset.

Top module: `strap_decoder`

## Requirements
- R1: Pin classes are GND=0, VDD=1, OUT1=2, OUT0=3. The class is found from two samples. Phase A drives probe1=0 and probe0=1. Phase B drives probe1=1 and probe0=0. The sample pair (A,B) maps as follows: 00→GND, 11→VDD, 01→OUT1, 10→OUT0.
- R2: Until done, the probes drive the phase A pattern during reset and phase 0, and the phase B pattern after that. Once done, probe1_o follows func1_i and probe0_o follows func0_i.
- R3: done_o goes high on rising edge 2*SETTLE+1 after reset is released. It stays high until the next reset.
- R4: Frequency index is taken from the classes of (sel0, sel1). The valid pairs are (GND,VDD)→0, (VDD,VDD)→1, (OUT1,VDD)→2, (GND,OUT1)→3, (VDD,OUT1)→4 and (OUT1,OUT1)→5. These stand for 433.92, 315.00, 434.15, 867.84, 868.30 and 917.00 MHz.
- R5: Modem index is taken from the classes of (sel2, sel3).
  - sel3=GND: sel2 GND, VDD, OUT1, OUT0 give 0, 1, 2, 3.
  - sel3=VDD: sel2 GND, VDD give 4, 5.
  - sel3=OUT1: sel2 GND, VDD, OUT1, OUT0 give 6, 7, 8, 9.
  - sel3=OUT0: sel2 GND, VDD, OUT1 give 10, 11, 12.
- R6: fsk_o is 1 exactly for modem indices 6 to 12. bw_code_o encodes the channel bandwidth as 100→0, 155→1, 185→2, 206→3, 275→4, 370→5 and 535→6 kHz. By index 0 to 12, the bandwidths are 206, 370, 370, 370, 535, 100, 155, 185, 275, 275, 535, 155, 275 kHz.
- R7: squelch_o is 1 only for modem indices 11 and 12.
- R8: clk_dis_o is 1 exactly when the clock-output pin is classed OUT0. This holds whether or not the selectors are valid.
- R9: If either the frequency pair or the modem pair is not in its table, invalid_o is 1. In that case the frequency index and the modem index are both 0, with the attributes of modem index 0 (OOK, code 3, no squelch).
- R10: After done, changes on the selector pins, the clock-output pin or the functional drivers leave every decoded output unchanged.
- R11: While reset is asserted, done_o, invalid_o, clk_dis_o, squelch_o, fsk_o and both indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 4 | Selector pins 0 to 3 |
| clkpin_i | input | 1 | Readback of the clock-output pin |
| func1_i | input | 1 | Functional driver for probe pin 1 |
| func0_i | input | 1 | Functional driver for probe pin 0 |
| probe1_o | output | 1 | Probe pin 1 |
| probe0_o | output | 1 | Probe pin 0 |
| done_o | output | 1 | Decoding finished |
| freq_idx_o | output | 3 | Carrier-frequency index |
| modem_idx_o | output | 4 | Modem configuration index |
| fsk_o | output | 1 | 1 = frequency shift keying, 0 = on-off keying |
| bw_code_o | output | 3 | Channel bandwidth code |
| squelch_o | output | 1 | Squelch enable |
| clk_dis_o | output | 1 | System clock output disabled |
| invalid_o | output | 1 | Unmapped selector combination |

## Verification
Each rising edge after reset release is counted, and the probe pins and done_o are compared on every falling edge.

- The probe patterns switch from phase A to phase B after edge SETTLE.
- done_o must appear after edge 2*SETTLE+1 and not one edge earlier.
- The decoded outputs are registered on that same edge, so they are read two falling edges later, once done is steady.
- Hold is checked three cycles after the pin wiring and the functional drivers have been changed.

// File: rtl/strap_decoder.sv
module strap_decoder #(
  parameter int SETTLE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sel_i,
  input  logic       clkpin_i,
  input  logic       func1_i,
  input  logic       func0_i,
  output logic       probe1_o,
  output logic       probe0_o,
  output logic       done_o,
  output logic [2:0] freq_idx_o,
  output logic [3:0] modem_idx_o,
  output logic       fsk_o,
  output logic [2:0] bw_code_o,
  output logic       squelch_o,
  output logic       clk_dis_o,
  output logic       invalid_o
);
  localparam int CW = (SETTLE < 4) ? 2 : $clog2(SETTLE);

  logic [4:0]    meta_q, sync_q, samp_a_q, samp_b_q;
  logic [1:0]    phase_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last     = (cnt_q == CW'(SETTLE - 1));
  assign done_o   = (phase_q == 2'd3);
  assign probe1_o = done_o ? func1_i : (phase_q != 2'd0);
  assign probe0_o = done_o ? func0_i : (phase_q == 2'd0);

  logic [1:0] c0, c1, c2, c3, ck;
  assign c0 = {samp_a_q[0] ^ samp_b_q[0], samp_a_q[0]};
  assign c1 = {samp_a_q[1] ^ samp_b_q[1], samp_a_q[1]};
  assign c2 = {samp_a_q[2] ^ samp_b_q[2], samp_a_q[2]};
  assign c3 = {samp_a_q[3] ^ samp_b_q[3], samp_a_q[3]};
  assign ck = {samp_a_q[4] ^ samp_b_q[4], samp_a_q[4]};

  logic       f_ok, m_ok;
  logic [2:0] f_idx;
  logic [3:0] m_base, m_idx, m_sel;
  logic [2:0] bw;

  assign f_ok  = (c0 != 2'd3) && (c1 == 2'd1 || c1 == 2'd2);
  assign f_idx = ((c1 == 2'd2) ? 3'd3 : 3'd0) + {1'b0, c0};

  always_comb begin
    case (c3)
      2'd0:    m_base = 4'd0;
      2'd1:    m_base = 4'd4;
      2'd2:    m_base = 4'd6;
      default: m_base = 4'd10;
    endcase
  end

  assign m_ok  = (c3 == 2'd0) || (c3 == 2'd2) ||
                 (c3 == 2'd1 && c2 <= 2'd1) || (c3 == 2'd3 && c2 != 2'd3);
  assign m_idx = m_base + {2'b00, c2};
  assign m_sel = (f_ok && m_ok) ? m_idx : 4'd0;

  always_comb begin
    case (m_sel)
      4'd0:                    bw = 3'd3;
      4'd1, 4'd2, 4'd3:        bw = 3'd5;
      4'd4, 4'd10:             bw = 3'd6;
      4'd5:                    bw = 3'd0;
      4'd6, 4'd11:             bw = 3'd1;
      4'd7:                    bw = 3'd2;
      default:                 bw = 3'd4;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q      <= '0;
      sync_q      <= '0;
      samp_a_q    <= '0;
      samp_b_q    <= '0;
      phase_q     <= 2'd0;
      cnt_q       <= '0;
      freq_idx_o  <= '0;
      modem_idx_o <= '0;
      fsk_o       <= 1'b0;
      bw_code_o   <= '0;
      squelch_o   <= 1'b0;
      clk_dis_o   <= 1'b0;
      invalid_o   <= 1'b0;
    end else begin
      meta_q <= {clkpin_i, sel_i};
      sync_q <= meta_q;
      case (phase_q)
        2'd0, 2'd1: begin
          if (last) begin
            cnt_q   <= '0;
            phase_q <= phase_q + 2'd1;
            if (phase_q == 2'd0) samp_a_q <= sync_q;
            else                 samp_b_q <= sync_q;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        2'd2: begin
          phase_q     <= 2'd3;
          freq_idx_o  <= (f_ok && m_ok) ? f_idx : 3'd0;
          modem_idx_o <= m_sel;
          fsk_o       <= (m_sel >= 4'd6);
          bw_code_o   <= bw;
          squelch_o   <= (m_sel == 4'd11) || (m_sel == 4'd12);
          clk_dis_o   <= (ck == 2'd3);
          invalid_o   <= !(f_ok && m_ok);
        end
        default: ;
      endcase
    end
  end

  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  assert_probe_patterns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (probe1_o != probe0_o));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable({freq_idx_o, modem_idx_o, fsk_o, bw_code_o, squelch_o, clk_dis_o, invalid_o}));

  assert_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (freq_idx_o == 3'd0 && modem_idx_o == 4'd0));

  assert_squelch_fsk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    squelch_o |-> fsk_o);

  assert_freq_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    freq_idx_o <= 3'd5);

  assert_modem_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    modem_idx_o <= 4'd12);
endmodule

// File: tb/strap_decoder_bench.sv
`timescale 1ns/1ps
module strap_decoder_bench;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic func1 = 1'b0, func0 = 1'b0;
  logic [1:0] tie [0:4];
  logic [3:0] sel;
  logic clkpin;
  logic p1, p0, done, fsk, sq, cdis, inv;
  logic [2:0] fidx, bwc;
  logic [3:0] midx;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic wire_of(input logic [1:0] t, input logic a1, input logic a0);
    case (t)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return a1;
      default: return a0;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) sel[i] = wire_of(tie[i], p1, p0);
    clkpin = wire_of(tie[4], p1, p0);
  end

  strap_decoder #(.SETTLE(S)) u_strap_decoder (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .clkpin_i(clkpin),
    .func1_i(func1), .func0_i(func0), .probe1_o(p1), .probe0_o(p0),
    .done_o(done), .freq_idx_o(fidx), .modem_idx_o(midx), .fsk_o(fsk),
    .bw_code_o(bwc), .squelch_o(sq), .clk_dis_o(cdis), .invalid_o(inv));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (ties %0d %0d %0d %0d %0d)",
               req, act, exp, tie[0], tie[1], tie[2], tie[3], tie[4]);
    end
  endtask

  function automatic int khz_code(input int k);
    case (k)
      100: return 0; 155: return 1; 185: return 2; 206: return 3;
      275: return 4; 370: return 5; default: return 6;
    endcase
  endfunction

  task automatic run_case(input int t0, input int t1, input int t2, input int t3, input int t4);
    int ef, em, ekhz;
    bit fv, mv;
    rst_n = 1'b0;
    tie[0] = 2'(t0); tie[1] = 2'(t1); tie[2] = 2'(t2); tie[3] = 2'(t3); tie[4] = 2'(t4);
    func1 = 1'(t0 + t3); func0 = 1'(t1 + t4);
    @(negedge clk); @(negedge clk);
    chk("R11 done in reset", done, 0);
    chk("R11 indices in reset", {fidx, midx}, 0);
    chk("R11 flags in reset", {fsk, sq, cdis, inv}, 0);
    chk("R2 probes in reset", {p1, p0}, 1);
    rst_n = 1'b1;
    for (int k = 1; k <= 2*S + 3; k++) begin
      @(negedge clk);
      chk("R3 done timing", done, (k >= 2*S + 1) ? 1 : 0);
      if (k >= 2*S + 1) chk("R2 probes released", {p1, p0}, {func1, func0});
      else if (k < S)   chk("R2 phase A pattern", {p1, p0}, 1);
      else              chk("R2 phase B pattern", {p1, p0}, 2);
    end
    fv = 1; ef = 0;
    case ({t0[1:0], t1[1:0]})
      4'b0001: ef = 0; 4'b0101: ef = 1; 4'b1001: ef = 2;
      4'b0010: ef = 3; 4'b0110: ef = 4; 4'b1010: ef = 5;
      default: fv = 0;
    endcase
    mv = 1; em = 0; ekhz = 206;
    case ({t2[1:0], t3[1:0]})
      4'b0000: begin em = 0;  ekhz = 206; end
      4'b0100: begin em = 1;  ekhz = 370; end
      4'b1000: begin em = 2;  ekhz = 370; end
      4'b1100: begin em = 3;  ekhz = 370; end
      4'b0001: begin em = 4;  ekhz = 535; end
      4'b0101: begin em = 5;  ekhz = 100; end
      4'b0010: begin em = 6;  ekhz = 155; end
      4'b0110: begin em = 7;  ekhz = 185; end
      4'b1010: begin em = 8;  ekhz = 275; end
      4'b1110: begin em = 9;  ekhz = 275; end
      4'b0011: begin em = 10; ekhz = 535; end
      4'b0111: begin em = 11; ekhz = 155; end
      4'b1011: begin em = 12; ekhz = 275; end
      default: mv = 0;
    endcase
    if (!(fv && mv)) begin ef = 0; em = 0; ekhz = 206; end
    chk("R9 invalid flag", inv, (fv && mv) ? 0 : 1);
    chk("R4 R1 frequency index", fidx, ef);
    chk("R5 R1 modem index", midx, em);
    chk("R6 modulation", fsk, (em >= 6) ? 1 : 0);
    chk("R6 bandwidth code", bwc, khz_code(ekhz));
    chk("R7 squelch", sq, (em == 11 || em == 12) ? 1 : 0);
    chk("R8 clock disable", cdis, (t4 == 3) ? 1 : 0);
    for (int i = 0; i < 5; i++) tie[i] = tie[i] + 2'd1;
    func1 = ~func1; func0 = ~func0;
    repeat (3) @(negedge clk);
    chk("R10 frequency held", fidx, ef);
    chk("R10 modem held", midx, em);
    chk("R10 flags held", {inv, cdis, sq}, {(fv && mv) ? 1'b0 : 1'b1, (t4 == 3) ? 1'b1 : 1'b0, (em == 11 || em == 12) ? 1'b1 : 1'b0});
    chk("R3 done held", done, 1);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) tie[i] = 2'd0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            for (int e = 0; e < 4; e++)
              run_case(a, b, c, d, e);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    $display("FAIL R3 watchdog expired: done %0d expected 1", done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule